// File: doc/BRIEF.md
# Page Rights Narrowing Unit

This block executes a privileged command that can only ever reduce the read, write and execute rights of one page held in a protected-page metadata table. The caller supplies the command's privilege level, the address of a rights descriptor together with the descriptor's reserved bits and its R/W/X flags, the target page address, a flag telling whether another modify-type command currently holds the page, the initialized state of the container that owns the page, and the current arithmetic flag word.

After a start pulse the unit walks a fixed chain of checks, one per clock. A check can end the command with a general-protection fault, a page-fault, or a non-fatal status code. When every check passes, the unit marks the page as being restricted and ANDs each of its R, W and X rights with the matching descriptor flag. A one-cycle done pulse reports the result kind, the status value and the updated flag word. The metadata table sits inside the unit. It has a load port that fills entries and a read port that returns any entry.

Top module: `ppr_unit`

## Requirements
- R1: If the command's privilege level is not 0, the command ends at check position 0 with a general-protection fault (kind code 2'b10).
- R2: A descriptor address with any of its low 6 bits set gives a general-protection fault at position 1. Otherwise, a page address with any of its low 12 bits set gives a general-protection fault at position 2. The descriptor test is made first.
- R3: A page address below REGION_BASE, or at or above REGION_BASE + NUM_PAGES*4096, gives a page-fault (kind 2'b11) at position 3. Inside the region, the table index is (page address - REGION_BASE) / 4096.
- R4: Nonzero reserved descriptor bits, or a descriptor with R=0 and W=1, give a general-protection fault at position 4.
- R5: An entry whose valid bit is 0 gives a page-fault at position 5.
- R6: If the page-held input is 1, the command ends at position 6 with status kind (2'b01) and status value 8'h03, and the entry is left unchanged. This holds even when the entry is also pending or modified.
- R7: An entry whose pending or modified bit is set ends at position 7 with status kind and status value 8'h02, and the entry is left unchanged.
- R8: A page type other than 3'd1 gives a page-fault at position 8. Otherwise, an owning container that is not initialized gives a general-protection fault at position 9.
- R9: On success (position 10, kind 2'b00, status 8'h00), the entry's restriction bit is set and each of R, W and X becomes its old value ANDed with the descriptor flag. Valid, pending, modified and type are kept. The entry layout is {valid[9], pending[8], modified[7], type[6:4], restricting[3], R[2], W[1], X[0]}.
- R10: A descriptor flag of 1 never sets a right that is 0 in the entry, so rights are never widened.
- R11: The flag word is laid out as {ZF[5], SF[4], OF[3], AF[2], PF[1], CF[0]}. On a status completion it becomes 6'b100000, on success it becomes 6'b000000, and on a fault it equals the flag word captured at start.
- R12: done is a one-cycle pulse exactly k+1 clocks after the edge that accepts start, where k is the check position that ends the command.
- R13: A table load written at one edge can be read from the table read port, combinationally, after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a command when the unit is idle |
| cpl_i | input | 2 | Privilege level of the command |
| desc_addr_i | input | ADDR_W | Descriptor address |
| page_addr_i | input | ADDR_W | Target page address |
| desc_rsvd_i | input | RSVD_W | Reserved descriptor bits |
| desc_r_i | input | 1 | Descriptor read flag |
| desc_w_i | input | 1 | Descriptor write flag |
| desc_x_i | input | 1 | Descriptor execute flag |
| page_held_i | input | 1 | Page held by another modify command |
| ctr_init_i | input | 1 | Owning container initialized |
| flags_i | input | 6 | Flag word at command start |
| done_o | output | 1 | Completion pulse |
| kind_o | output | 2 | Result kind |
| status_o | output | 8 | Status value |
| flags_o | output | 6 | Flag word after completion |
| tbl_ld_en_i | input | 1 | Table load enable |
| tbl_ld_idx_i | input | IDX_W | Table load index |
| tbl_ld_data_i | input | 10 | Table load entry |
| tbl_rd_idx_i | input | IDX_W | Table read index |
| tbl_rd_data_o | output | 10 | Table read entry |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, 16 table pages, 8 reserved descriptor bits, and a region base of 0x0010_0000. Because the base is nonzero, addresses below the region can be tested. Because the table is small, the first address past the top of the region and the last valid page (index 15) can both be tested. Each check position is driven to be the one that ends a command, so the latency of every exit can be measured along with its kind, status and flag word.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
    typedef enum logic [1:0] {
        KIND_OK     = 2'b00,
        KIND_STATUS = 2'b01,
        KIND_GP     = 2'b10,
        KIND_PF     = 2'b11
    } kind_e;

    typedef struct packed {
        logic       valid;
        logic       pending;
        logic       modified;
        logic [2:0] ptype;
        logic       restr;
        logic       r;
        logic       w;
        logic       x;
    } ent_t;

    localparam int ENT_W    = $bits(ent_t);
    localparam int STATUS_W = 8;
    localparam int FLAGS_W  = 6;
    localparam int STEP_W   = 4;

    localparam logic [2:0]          PTYPE_REG     = 3'd1;
    localparam logic [STATUS_W-1:0] STAT_NONE     = 8'h00;
    localparam logic [STATUS_W-1:0] STAT_NOTMOD   = 8'h02;
    localparam logic [STATUS_W-1:0] STAT_CONFLICT = 8'h03;

    // check chain positions, evaluated in this order
    localparam logic [STEP_W-1:0] STEP_PRIV    = 4'd0;
    localparam logic [STEP_W-1:0] STEP_DALIGN  = 4'd1;
    localparam logic [STEP_W-1:0] STEP_PALIGN  = 4'd2;
    localparam logic [STEP_W-1:0] STEP_REGION  = 4'd3;
    localparam logic [STEP_W-1:0] STEP_DESC    = 4'd4;
    localparam logic [STEP_W-1:0] STEP_VALID   = 4'd5;
    localparam logic [STEP_W-1:0] STEP_HELD    = 4'd6;
    localparam logic [STEP_W-1:0] STEP_PENDMOD = 4'd7;
    localparam logic [STEP_W-1:0] STEP_TYPE    = 4'd8;
    localparam logic [STEP_W-1:0] STEP_INIT    = 4'd9;
    localparam logic [STEP_W-1:0] STEP_COMMIT  = 4'd10;
endpackage

// File: rtl/ppr_addr_decode.sv
`timescale 1ns/1ps
module ppr_addr_decode #(
    parameter int                ADDR_W      = 32,
    parameter int                PAGE_SHIFT  = 12,
    parameter int                DESC_SHIFT  = 6,
    parameter int                NUM_PAGES   = 16,
    parameter int                IDX_W       = 4,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic [ADDR_W-1:0] page_addr_i,
    output logic              desc_ok_o,
    output logic              page_ok_o,
    output logic              in_region_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W-1:0] DESC_MASK   = ADDR_W'((64'd1 << DESC_SHIFT) - 64'd1);
    localparam logic [ADDR_W-1:0] PAGE_MASK   = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [ADDR_W:0]   REGION_SPAN = (ADDR_W+1)'(64'(NUM_PAGES) << PAGE_SHIFT);

    logic [ADDR_W:0] off;

    always_comb begin
        desc_ok_o   = (desc_addr_i & DESC_MASK) == '0;
        page_ok_o   = (page_addr_i & PAGE_MASK) == '0;
        off         = {1'b0, page_addr_i} - {1'b0, REGION_BASE};
        // a borrow out of the top bit means the address lies below the base
        in_region_o = !off[ADDR_W] && (off < REGION_SPAN);
        idx_o       = IDX_W'(off[ADDR_W-1:0] >> PAGE_SHIFT);
    end
endmodule

// File: rtl/ppr_table.sv
`timescale 1ns/1ps
module ppr_table
    import ppr_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  ent_t             ld_data_i,
    input  logic             upd_en_i,
    input  logic [IDX_W-1:0] upd_idx_i,
    input  ent_t             upd_data_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    output ent_t             lk_data_o,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ent_t             rd_data_o
);
    ent_t [NUM_PAGES-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (ld_en_i && (ld_idx_i == IDX_W'(i)))
                mem_d[i] = ld_data_i;
            // a committing command wins over a load to the same page
            if (upd_en_i && (upd_idx_i == IDX_W'(i)))
                mem_d[i] = upd_data_i;
        end
        lk_data_o = mem_q[lk_idx_i];
        rd_data_o = mem_q[rd_idx_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // rights written back by a command are never wider than the stored ones
    assert_no_widen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |-> ((upd_data_i.r & ~mem_q[upd_idx_i].r) == 1'b0) &&
                     ((upd_data_i.w & ~mem_q[upd_idx_i].w) == 1'b0) &&
                     ((upd_data_i.x & ~mem_q[upd_idx_i].x) == 1'b0));

    // a committed command leaves the entry in the table as written
    assert_commit_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> mem_q[$past(upd_idx_i)] == $past(upd_data_i));
endmodule

// File: rtl/ppr_seq.sv
`timescale 1ns/1ps
module ppr_seq
    import ppr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RSVD_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          cpl_i,
    input  logic [ADDR_W-1:0]   desc_addr_i,
    input  logic [ADDR_W-1:0]   page_addr_i,
    input  logic [RSVD_W-1:0]   desc_rsvd_i,
    input  logic                desc_r_i,
    input  logic                desc_w_i,
    input  logic                desc_x_i,
    input  logic                page_held_i,
    input  logic                ctr_init_i,
    input  logic [FLAGS_W-1:0]  flags_i,
    // captured addresses go out to the decoder, its verdicts come back
    output logic [ADDR_W-1:0]   cap_daddr_o,
    output logic [ADDR_W-1:0]   cap_paddr_o,
    input  logic                desc_ok_i,
    input  logic                page_ok_i,
    input  logic                in_region_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  ent_t                ent_i,
    output logic                upd_en_o,
    output logic [IDX_W-1:0]    upd_idx_o,
    output ent_t                upd_data_o,
    output logic                done_o,
    output logic [1:0]          kind_o,
    output logic [STATUS_W-1:0] status_o,
    output logic [FLAGS_W-1:0]  flags_o
);
    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    typedef struct packed {
        st_e                 st;
        logic [STEP_W-1:0]   step;
        logic [1:0]          cpl;
        logic [ADDR_W-1:0]   daddr;
        logic [ADDR_W-1:0]   paddr;
        logic [RSVD_W-1:0]   rsvd;
        logic                r;
        logic                w;
        logic                x;
        logic                held;
        logic                init;
        logic [FLAGS_W-1:0]  flags_in;
        logic                done;
        kind_e               kind;
        logic [STATUS_W-1:0] status;
        logic [FLAGS_W-1:0]  flags_out;
    } seq_t;

    seq_t                q, d;
    logic                fin;
    kind_e               fin_kind;
    logic [STATUS_W-1:0] fin_stat;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        fin        = 1'b0;
        fin_kind   = KIND_OK;
        fin_stat   = STAT_NONE;
        upd_en_o   = 1'b0;
        upd_idx_o  = idx_i;
        upd_data_o = ent_i;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_RUN;
                    d.step     = STEP_PRIV;
                    d.cpl      = cpl_i;
                    d.daddr    = desc_addr_i;
                    d.paddr    = page_addr_i;
                    d.rsvd     = desc_rsvd_i;
                    d.r        = desc_r_i;
                    d.w        = desc_w_i;
                    d.x        = desc_x_i;
                    d.held     = page_held_i;
                    d.init     = ctr_init_i;
                    d.flags_in = flags_i;
                end
            end
            default: begin
                case (q.step)
                    STEP_PRIV:    if (q.cpl != 2'd0)          begin fin = 1'b1; fin_kind = KIND_GP; end
                    STEP_DALIGN:  if (!desc_ok_i)             begin fin = 1'b1; fin_kind = KIND_GP; end
                    STEP_PALIGN:  if (!page_ok_i)             begin fin = 1'b1; fin_kind = KIND_GP; end
                    STEP_REGION:  if (!in_region_i)           begin fin = 1'b1; fin_kind = KIND_PF; end
                    STEP_DESC:    if ((|q.rsvd) || (!q.r && q.w))
                                                              begin fin = 1'b1; fin_kind = KIND_GP; end
                    STEP_VALID:   if (!ent_i.valid)           begin fin = 1'b1; fin_kind = KIND_PF; end
                    STEP_HELD:    if (q.held) begin
                                      fin      = 1'b1;
                                      fin_kind = KIND_STATUS;
                                      fin_stat = STAT_CONFLICT;
                                  end
                    STEP_PENDMOD: if (ent_i.pending || ent_i.modified) begin
                                      fin      = 1'b1;
                                      fin_kind = KIND_STATUS;
                                      fin_stat = STAT_NOTMOD;
                                  end
                    STEP_TYPE:    if (ent_i.ptype != PTYPE_REG) begin fin = 1'b1; fin_kind = KIND_PF; end
                    STEP_INIT:    if (!q.init)                begin fin = 1'b1; fin_kind = KIND_GP; end
                    default: begin
                        fin              = 1'b1;
                        upd_en_o         = 1'b1;
                        upd_data_o.restr = 1'b1;
                        upd_data_o.r     = ent_i.r & q.r;
                        upd_data_o.w     = ent_i.w & q.w;
                        upd_data_o.x     = ent_i.x & q.x;
                    end
                endcase

                if (fin) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.kind   = fin_kind;
                    d.status = fin_stat;
                    if (fin_kind == KIND_GP || fin_kind == KIND_PF)
                        d.flags_out = q.flags_in;
                    else
                        d.flags_out = {fin_kind == KIND_STATUS, 5'b0};
                end else begin
                    d.step = q.step + STEP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cap_daddr_o = q.daddr;
    assign cap_paddr_o = q.paddr;
    assign done_o      = q.done;
    assign kind_o      = q.kind;
    assign status_o    = q.status;
    assign flags_o     = q.flags_out;

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_priv_gp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.step == STEP_PRIV && q.cpl != 2'd0)
            |=> (q.done && q.kind == KIND_GP));

    assert_commit_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_o |-> (ent_i.valid && !ent_i.pending && !ent_i.modified &&
                      ent_i.ptype == PTYPE_REG && q.init && !q.held && in_region_i));

    assert_commit_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_o |=> (q.done && q.kind == KIND_OK && q.status == STAT_NONE));

    assert_status_zf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.kind == KIND_STATUS) |-> (q.flags_out == 6'b100000));
endmodule

// File: rtl/ppr_unit.sv
`timescale 1ns/1ps
module ppr_unit
    import ppr_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                PAGE_SHIFT  = 12,
    parameter int                DESC_SHIFT  = 6,
    parameter int                NUM_PAGES   = 16,
    parameter int                RSVD_W      = 8,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0010_0000,
    localparam int               IDX_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          cpl_i,
    input  logic [ADDR_W-1:0]   desc_addr_i,
    input  logic [ADDR_W-1:0]   page_addr_i,
    input  logic [RSVD_W-1:0]   desc_rsvd_i,
    input  logic                desc_r_i,
    input  logic                desc_w_i,
    input  logic                desc_x_i,
    input  logic                page_held_i,
    input  logic                ctr_init_i,
    input  logic [FLAGS_W-1:0]  flags_i,
    output logic                done_o,
    output logic [1:0]          kind_o,
    output logic [STATUS_W-1:0] status_o,
    output logic [FLAGS_W-1:0]  flags_o,
    input  logic                tbl_ld_en_i,
    input  logic [IDX_W-1:0]    tbl_ld_idx_i,
    input  logic [ENT_W-1:0]    tbl_ld_data_i,
    input  logic [IDX_W-1:0]    tbl_rd_idx_i,
    output logic [ENT_W-1:0]    tbl_rd_data_o
);
    logic [ADDR_W-1:0] cap_daddr, cap_paddr;
    logic              desc_ok, page_ok, in_region;
    logic [IDX_W-1:0]  idx;
    ent_t              lk_ent, upd_ent, rd_ent;
    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;

    ppr_addr_decode #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DESC_SHIFT(DESC_SHIFT),
        .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .REGION_BASE(REGION_BASE)
    ) u_dec (
        .desc_addr_i (cap_daddr),
        .page_addr_i (cap_paddr),
        .desc_ok_o   (desc_ok),
        .page_ok_o   (page_ok),
        .in_region_o (in_region),
        .idx_o       (idx)
    );

    ppr_table #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en_i    (tbl_ld_en_i),
        .ld_idx_i   (tbl_ld_idx_i),
        .ld_data_i  (ent_t'(tbl_ld_data_i)),
        .upd_en_i   (upd_en),
        .upd_idx_i  (upd_idx),
        .upd_data_i (upd_ent),
        .lk_idx_i   (idx),
        .lk_data_o  (lk_ent),
        .rd_idx_i   (tbl_rd_idx_i),
        .rd_data_o  (rd_ent)
    );

    ppr_seq #(.ADDR_W(ADDR_W), .RSVD_W(RSVD_W), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cpl_i       (cpl_i),
        .desc_addr_i (desc_addr_i),
        .page_addr_i (page_addr_i),
        .desc_rsvd_i (desc_rsvd_i),
        .desc_r_i    (desc_r_i),
        .desc_w_i    (desc_w_i),
        .desc_x_i    (desc_x_i),
        .page_held_i (page_held_i),
        .ctr_init_i  (ctr_init_i),
        .flags_i     (flags_i),
        .cap_daddr_o (cap_daddr),
        .cap_paddr_o (cap_paddr),
        .desc_ok_i   (desc_ok),
        .page_ok_i   (page_ok),
        .in_region_i (in_region),
        .idx_i       (idx),
        .ent_i       (lk_ent),
        .upd_en_o    (upd_en),
        .upd_idx_o   (upd_idx),
        .upd_data_o  (upd_ent),
        .done_o      (done_o),
        .kind_o      (kind_o),
        .status_o    (status_o),
        .flags_o     (flags_o)
    );

    assign tbl_rd_data_o = rd_ent;
endmodule

// File: tb/ppr_unit_tb.sv
`timescale 1ns/1ps
module ppr_unit_tb;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic [31:0] daddr = 32'h0000_8040;
    logic [31:0] paddr = BASE;
    logic [7:0]  rsvd = 8'h00;
    logic        fr = 1'b1, fw = 1'b1, fx = 1'b1;
    logic        held = 1'b0, init = 1'b1;
    logic [5:0]  flags_in = 6'b101010;
    logic        done;
    logic [1:0]  kind;
    logic [7:0]  status;
    logic [5:0]  flags_out;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0, rd_idx = '0;
    logic [9:0]  ld_data = '0, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ppr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cpl_i(cpl),
        .desc_addr_i(daddr), .page_addr_i(paddr), .desc_rsvd_i(rsvd),
        .desc_r_i(fr), .desc_w_i(fw), .desc_x_i(fx),
        .page_held_i(held), .ctr_init_i(init), .flags_i(flags_in),
        .done_o(done), .kind_o(kind), .status_o(status), .flags_o(flags_out),
        .tbl_ld_en_i(ld_en), .tbl_ld_idx_i(ld_idx), .tbl_ld_data_i(ld_data),
        .tbl_rd_idx_i(rd_idx), .tbl_rd_data_o(rd_data)
    );

    localparam logic [1:0] K_OK = 2'b00, K_ST = 2'b01, K_GP = 2'b10, K_PF = 2'b11;

    function automatic logic [9:0] mk(input logic v, p, m, input logic [2:0] t,
                                      input logic rs, r, w, x);
        return {v, p, m, t, rs, r, w, x};
    endfunction

    function automatic logic [9:0] narrowed(input logic [9:0] e, input logic r, w, x);
        return {e[9:4], 1'b1, e[2] & r, e[1] & w, e[0] & x};
    endfunction

    localparam logic [9:0] GOOD = 10'b1_0_0_001_0_111;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [9:0] e);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_data = e;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic peek(input int idx, output logic [9:0] e);
        rd_idx = 4'(idx);
        #0.5;
        e = rd_data;
    endtask

    task automatic defaults(input int idx);
        cpl = 2'd0; daddr = 32'h0000_8040; paddr = BASE + (32'(idx) << 12);
        rsvd = 8'h00; fr = 1'b1; fw = 1'b1; fx = 1'b1;
        held = 1'b0; init = 1'b1; flags_in = 6'b101010;
    endtask

    // issue one command and check latency, result and table entry
    task automatic run(input string req, input int k, input logic [1:0] ek,
                       input logic [7:0] es, input logic [5:0] ef,
                       input int idx, input logic [9:0] eent);
        int cyc;
        logic [9:0] got;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done && cyc < 40);
        chk(req, "latency (R12)", 64'(cyc), 64'(k + 1));
        chk(req, "kind", 64'(kind), 64'(ek));
        chk(req, "status", 64'(status), 64'(es));
        chk(req, "flags (R11)", 64'(flags_out), 64'(ef));
        @(negedge clk);
        chk(req, "done one cycle (R12)", 64'(done), 64'd0);
        peek(idx, got);
        chk(req, "entry", 64'(got), 64'(eent));
    endtask

    task automatic t_reset();
        logic [9:0] e;
        chk("R12", "reset done", 64'(done), 64'd0);
        chk("R12", "reset kind", 64'(kind), 64'd0);
        chk("R11", "reset flags", 64'(flags_out), 64'd0);
        peek(3, e);
        chk("R13", "reset entry", 64'(e), 64'd0);
    endtask

    task automatic t_load_R13();
        logic [9:0] e;
        load(0, GOOD);
        peek(0, e);
        chk("R13", "load readback", 64'(e), 64'(GOOD));
    endtask

    task automatic t_priv_R1();
        load(1, GOOD);
        defaults(1); cpl = 2'd3;
        run("R1", 0, K_GP, 8'h00, 6'b101010, 1, GOOD);
        defaults(1); cpl = 2'd1; daddr = 32'h0000_8001;
        run("R1", 0, K_GP, 8'h00, 6'b101010, 1, GOOD);
    endtask

    task automatic t_align_R2();
        load(2, GOOD);
        defaults(2); daddr = 32'h0000_8020;
        run("R2", 1, K_GP, 8'h00, 6'b101010, 2, GOOD);
        defaults(2); paddr = BASE + 32'h0000_2800;
        run("R2", 2, K_GP, 8'h00, 6'b101010, 2, GOOD);
        defaults(2); daddr = 32'h0000_8008; paddr = BASE + 32'h0000_2004;
        run("R2", 1, K_GP, 8'h00, 6'b101010, 2, GOOD);
    endtask

    task automatic t_region_R3();
        defaults(0); paddr = BASE - 32'h1000;
        run("R3", 3, K_PF, 8'h00, 6'b101010, 0, GOOD);
        defaults(0); paddr = BASE + 32'h0001_0000;
        run("R3", 3, K_PF, 8'h00, 6'b101010, 0, GOOD);
    endtask

    task automatic t_desc_R4();
        load(4, GOOD);
        defaults(4); rsvd = 8'h80;
        run("R4", 4, K_GP, 8'h00, 6'b101010, 4, GOOD);
        defaults(4); fr = 1'b0; fw = 1'b1;
        run("R4", 4, K_GP, 8'h00, 6'b101010, 4, GOOD);
    endtask

    task automatic t_valid_R5();
        logic [9:0] e = mk(1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1);
        load(5, e);
        defaults(5);
        run("R5", 5, K_PF, 8'h00, 6'b101010, 5, e);
    endtask

    task automatic t_held_R6();
        logic [9:0] e = mk(1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1);
        load(6, GOOD);
        defaults(6); held = 1'b1;
        run("R6", 6, K_ST, 8'h03, 6'b100000, 6, GOOD);
        load(6, e);
        defaults(6); held = 1'b1;
        run("R6", 6, K_ST, 8'h03, 6'b100000, 6, e);
    endtask

    task automatic t_notmod_R7();
        logic [9:0] ep = mk(1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1);
        logic [9:0] em = mk(1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        load(7, ep);
        defaults(7);
        run("R7", 7, K_ST, 8'h02, 6'b100000, 7, ep);
        load(7, em);
        defaults(7);
        run("R7", 7, K_ST, 8'h02, 6'b100000, 7, em);
    endtask

    task automatic t_type_init_R8();
        logic [9:0] et = mk(1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        load(8, et);
        defaults(8);
        run("R8", 8, K_PF, 8'h00, 6'b101010, 8, et);
        load(8, GOOD);
        defaults(8); init = 1'b0;
        run("R8", 9, K_GP, 8'h00, 6'b101010, 8, GOOD);
    endtask

    task automatic t_success_R9();
        load(15, GOOD);
        defaults(15); fr = 1'b1; fw = 1'b0; fx = 1'b1; flags_in = 6'b111111;
        run("R9", 10, K_OK, 8'h00, 6'b000000, 15, narrowed(GOOD, 1'b1, 1'b0, 1'b1));
        defaults(15); fr = 1'b0; fw = 1'b0; fx = 1'b1;
        run("R9", 10, K_OK, 8'h00, 6'b000000, 15, 10'b1_0_0_001_1_001);
    endtask

    task automatic t_nowiden_R10();
        logic [9:0] e = mk(1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        load(9, e);
        defaults(9);
        run("R10", 10, K_OK, 8'h00, 6'b000000, 9, 10'b1_0_0_001_1_001);
        defaults(9); fr = 1'b0; fw = 1'b0; fx = 1'b0;
        run("R10", 10, K_OK, 8'h00, 6'b000000, 9, 10'b1_0_0_001_1_000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_R13();
        t_priv_R1();
        t_align_R2();
        t_region_R3();
        t_desc_R4();
        t_valid_R5();
        t_held_R6();
        t_notmod_R7();
        t_type_init_R8();
        t_success_R9();
        t_nowiden_R10();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule